// File: doc/BRIEF.md
# Queue Status and Interrupt Generator

This block watches a bank of 64 hardware queues and turns their fill levels into condition flags: empty, nearly empty, nearly full and full. The fill counters and the storage sit elsewhere. Each queue's current level arrives as an input, together with two 3-bit watermark codes that set its nearly-empty and nearly-full thresholds on a power-of-two scale. Overflow and underflow events also arrive as one-cycle pulses, and the block records them in sticky error bits.

The flags are gathered into 32-bit words that software reads through a word-addressed register port. The lower half of the bank (queues 0 to 31) reports all four flags and both error bits. The upper half (queues 32 to 63) reports only nearly empty and full. Each queue drives one interrupt line. The line is an interrupt status bit, gated by an enable bit. The status bit latches when a selected condition goes from false to true. For the lower half that condition is chosen by a per-queue 3-bit source code. The upper half always uses nearly empty.

Reads are combinational from `reg_addr`. Writes take effect at the clock edge where `reg_we` is high. Register words, by address: 0-3 lower status; 4-5 error bits; 6 upper nearly-empty; 7 upper full; 8-11 interrupt source codes; 12-13 interrupt enable; 14-15 interrupt status.

Top module: `qstat_irq_gen`

## Requirements
- R1: For queue n of 0..31, word n>>3 holds a 4-bit field at bit (n&7)*4. Within that field, bit 0 is empty (fill is 0) and bit 3 is full (fill equals the capacity of 64).
- R2: Watermark codes 0..7 decode to thresholds 0, 1, 2, 4, 8, 16, 32 and 64 entries. Nearly empty (field bit 1) is set when fill is at or below the nearly-empty threshold.
- R3: Nearly full (field bit 2) is set when free space, which is 64 minus fill, is at or below the nearly-full threshold. A full queue is always nearly full.
- R4: For queue n of 32..63, word 6 bit n-32 is nearly empty and word 7 bit n-32 is full.
- R5: An underflow pulse for queue n of 0..31 sets word 4+(n>>4) bit (n&15)*2. An overflow pulse sets the bit above it. Both bits hold until a 1 is written to them. A pulse in the same cycle as the clearing write leaves the bit set.
- R6: For queue n of 0..31, the source code sits in word 8+(n>>3) at bit (n&7)*4, and the top bit of each field always reads 0. Codes 0..3 select empty, nearly empty, nearly full and full. Codes 4..7 select the negation of those four, in the same order.
- R7: An interrupt status bit (word 14+(n>>5), bit n&31) sets when its selected condition rises from false to true. Writing 1 clears it. A condition that is already true when reset is released does not set it.
- R8: Enable bits (word 12+(n>>5), bit n&31) can be read and written. Each irq_out[n] is high exactly when both status bit n and enable bit n are set.
- R9: Queues 32..63 latch interrupt status on a rising nearly-empty condition, whatever else changes.
- R10: Writes to words 0-3, 6 and 7 have no effect. After reset, all source, enable, error and interrupt status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_lvl | input | 448 | Fill level per queue, 7 bits each, queue n at bits n*7 and up |
| ne_wm | input | 192 | Nearly-empty watermark code per queue, 3 bits each |
| nf_wm | input | 192 | Nearly-full watermark code per queue, 3 bits each |
| ovf_evt | input | 32 | Overflow pulse per lower queue |
| unf_evt | input | 32 | Underflow pulse per lower queue |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 64 | Interrupt line per queue |

## Verification
The hardest case to reach is a negated interrupt source. For these codes the condition is already true in the steady state, so the status bit can only be seen to latch after the condition has first been made false and the stale status has been cleared. For each of the eight codes, the bench drives queue 0's fill to a level where the condition is false, rewrites the source, clears the status with a write of 1, and confirms the bit stays clear. It then moves the fill across the watermark edge and expects the latch on the next edge. The second hard case is a clear and a new event in the same cycle, because the pulse and the clearing write must land on the same edge. The bench gets there by raising an underflow pulse in exactly the cycle of the write.

// File: rtl/qsig_pkg.sv
`timescale 1ns/1ps
package qsig_pkg;

    // Per-queue condition flags; packed so that empty lands on bit 0
    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qflags_t;

    typedef enum logic [2:0] {
        SRC_EMPTY      = 3'd0,
        SRC_NEMPTY     = 3'd1,
        SRC_NFULL      = 3'd2,
        SRC_FULL       = 3'd3,
        SRC_NOT_EMPTY  = 3'd4,
        SRC_NOT_NEMPTY = 3'd5,
        SRC_NOT_NFULL  = 3'd6,
        SRC_NOT_FULL   = 3'd7
    } irq_src_e;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 4;
    localparam int ERR_W    = 2;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
    localparam int ERRS_PER_WORD   = WORD_W / ERR_W;

    // Logarithmic watermark decode: 0 -> 0, k -> 2^(k-1)
    function automatic logic [7:0] wm_thresh(input logic [2:0] code);
        logic [7:0] t;
        if (code == 3'd0) t = 8'd0;
        else              t = 8'd1 << (code - 3'd1);
        return t;
    endfunction

    // Pick one flag by the low two bits, invert when the top bit is set
    function automatic logic sel_cond(input qflags_t f, input logic [2:0] code);
        logic base;
        case (code[1:0])
            2'd0:    base = f.empty;
            2'd1:    base = f.nempty;
            2'd2:    base = f.nfull;
            default: base = f.full;
        endcase
        return code[2] ? ~base : base;
    endfunction

endpackage

// File: rtl/qsig_flags.sv
`timescale 1ns/1ps
module qsig_flags
    import qsig_pkg::*;
#(
    parameter int CAP = 64,
    parameter int LW  = 7
) (
    input  logic [LW-1:0] fill,
    input  logic [2:0]    ne_code,
    input  logic [2:0]    nf_code,
    output qflags_t       flags
);
    logic [LW-1:0] free_lvl;
    logic [7:0]    thr_ne;
    logic [7:0]    thr_nf;

    always_comb begin
        free_lvl     = LW'(CAP) - fill;
        thr_ne       = wm_thresh(ne_code);
        thr_nf       = wm_thresh(nf_code);
        flags.empty  = (fill == '0);
        flags.full   = (fill == LW'(CAP));
        flags.nempty = (32'(fill) <= 32'(thr_ne));
        flags.nfull  = (32'(free_lvl) <= 32'(thr_nf));
    end
endmodule

// File: rtl/qsig_sticky.sv
`timescale 1ns/1ps
module qsig_sticky #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] bits
);
    // a new event outranks a clear arriving on the same edge
    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= (bits & ~clr) | set_evt;
    end
endmodule

// File: rtl/qsig_irq.sv
`timescale 1ns/1ps
module qsig_irq #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    assign rise = cond & ~prev_q;

    // prev starts high so a condition true at reset release is not an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '1;
            stat   <= '0;
        end else begin
            prev_q <= cond;
            stat   <= (stat & ~clr) | rise;
        end
    end
endmodule

// File: rtl/qstat_irq_gen.sv
`timescale 1ns/1ps
module qstat_irq_gen
    import qsig_pkg::*;
#(
    parameter int NQ  = 64,
    parameter int CAP = 64,
    parameter int LW  = 7,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ*LW-1:0]  fill_lvl,
    input  logic [NQ*3-1:0]   ne_wm,
    input  logic [NQ*3-1:0]   nf_wm,
    input  logic [NQ/2-1:0]   ovf_evt,
    input  logic [NQ/2-1:0]   unf_evt,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NQ-1:0]     irq_out
);
    localparam int N_LO       = NQ / 2;
    localparam int N_HI       = NQ - N_LO;
    localparam int STAT_WORDS = N_LO / FIELDS_PER_WORD;
    localparam int ERR_WORDS  = N_LO / ERRS_PER_WORD;
    localparam int UP_WORDS   = N_HI / WORD_W;
    localparam int SRC_WORDS  = N_LO / FIELDS_PER_WORD;
    localparam int BIT_WORDS  = NQ / WORD_W;
    localparam int A_STAT     = 0;
    localparam int A_ERR      = A_STAT + STAT_WORDS;
    localparam int A_UPNE     = A_ERR + ERR_WORDS;
    localparam int A_UPF      = A_UPNE + UP_WORDS;
    localparam int A_SRC      = A_UPF + UP_WORDS;
    localparam int A_EN       = A_SRC + SRC_WORDS;
    localparam int A_IST      = A_EN + BIT_WORDS;

    qflags_t               qf [NQ];
    logic [NQ*FIELD_W-1:0] flags_flat;
    logic [N_LO*FIELD_W-1:0] stat_flat;
    logic [N_LO*ERR_W-1:0] err_flat;
    logic [N_LO*ERR_W-1:0] err_clr_flat;
    logic [N_HI-1:0]       upne_flat;
    logic [N_HI-1:0]       upf_flat;
    logic [N_LO*FIELD_W-1:0] src_flat;
    logic [2:0]            src_q [N_LO];
    logic [NQ-1:0]         en_q;
    logic [NQ-1:0]         ist_q;
    logic [NQ-1:0]         ist_clr;
    logic [NQ-1:0]         irq_cond;
    logic [N_LO-1:0]       unf_bits;
    logic [N_LO-1:0]       ovf_bits;
    logic [N_LO-1:0]       unf_clr;
    logic [N_LO-1:0]       ovf_clr;
    int                    widx;

    assign widx = int'(reg_addr);

    // ---------------- per-queue flag evaluation ----------------
    for (genvar q = 0; q < NQ; q++) begin : g_q
        qsig_flags #(.CAP(CAP), .LW(LW)) u_flags (
            .fill    (fill_lvl[q*LW +: LW]),
            .ne_code (ne_wm[q*3 +: 3]),
            .nf_code (nf_wm[q*3 +: 3]),
            .flags   (qf[q])
        );
        assign flags_flat[q*FIELD_W +: FIELD_W] = qf[q];

        if (q < N_LO) begin : g_lo
            assign stat_flat[q*FIELD_W +: FIELD_W] = qf[q];
            assign src_flat[q*FIELD_W +: FIELD_W]  = {1'b0, src_q[q]};
            assign irq_cond[q] = sel_cond(qf[q], src_q[q]);
            assign err_flat[q*ERR_W]     = unf_bits[q];
            assign err_flat[q*ERR_W + 1] = ovf_bits[q];
            assign unf_clr[q] = err_clr_flat[q*ERR_W];
            assign ovf_clr[q] = err_clr_flat[q*ERR_W + 1];
        end else begin : g_hi
            assign upne_flat[q-N_LO] = qf[q].nempty;
            assign upf_flat[q-N_LO]  = qf[q].full;
            assign irq_cond[q]       = qf[q].nempty;
        end
    end

    // ---------------- write-one-to-clear masks ----------------
    always_comb begin
        err_clr_flat = '0;
        ist_clr      = '0;
        for (int w = 0; w < ERR_WORDS; w++)
            if (reg_we && widx == A_ERR + w)
                err_clr_flat[w*WORD_W +: WORD_W] = reg_wdata;
        for (int w = 0; w < BIT_WORDS; w++)
            if (reg_we && widx == A_IST + w)
                ist_clr[w*WORD_W +: WORD_W] = reg_wdata;
    end

    qsig_sticky #(.N(N_LO)) u_unf (
        .clk (clk), .rst (rst), .set_evt (unf_evt), .clr (unf_clr), .bits (unf_bits)
    );
    qsig_sticky #(.N(N_LO)) u_ovf (
        .clk (clk), .rst (rst), .set_evt (ovf_evt), .clr (ovf_clr), .bits (ovf_bits)
    );

    qsig_irq #(.N(NQ)) u_irq (
        .clk (clk), .rst (rst), .cond (irq_cond), .clr (ist_clr), .stat (ist_q)
    );

    // ---------------- writable configuration ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < N_LO; q++) src_q[q] <= SRC_EMPTY;
            en_q <= '0;
        end else if (reg_we) begin
            for (int w = 0; w < SRC_WORDS; w++)
                if (widx == A_SRC + w)
                    for (int k = 0; k < FIELDS_PER_WORD; k++)
                        src_q[w*FIELDS_PER_WORD + k] <= reg_wdata[k*FIELD_W +: 3];
            for (int w = 0; w < BIT_WORDS; w++)
                if (widx == A_EN + w)
                    en_q[w*WORD_W +: WORD_W] <= reg_wdata;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (widx < A_ERR)
            reg_rdata = stat_flat[(widx - A_STAT)*WORD_W +: WORD_W];
        else if (widx < A_UPNE)
            reg_rdata = err_flat[(widx - A_ERR)*WORD_W +: WORD_W];
        else if (widx < A_UPF)
            reg_rdata = upne_flat[(widx - A_UPNE)*WORD_W +: WORD_W];
        else if (widx < A_SRC)
            reg_rdata = upf_flat[(widx - A_UPF)*WORD_W +: WORD_W];
        else if (widx < A_EN)
            reg_rdata = src_flat[(widx - A_SRC)*WORD_W +: WORD_W];
        else if (widx < A_IST)
            reg_rdata = en_q[(widx - A_EN)*WORD_W +: WORD_W];
        else if (widx < A_IST + BIT_WORDS)
            reg_rdata = ist_q[(widx - A_IST)*WORD_W +: WORD_W];
    end

    assign irq_out = ist_q & en_q;

endmodule

// File: rtl/qsig_chk.sv
`timescale 1ns/1ps
module qsig_chk #(
    parameter int NQ = 64,
    parameter int AW = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [AW-1:0]    reg_addr,
    input logic [31:0]      reg_rdata,
    input logic [NQ*4-1:0]  flags_flat,
    input logic [NQ-1:0]    err_flat,
    input logic [NQ-1:0]    irq_cond,
    input logic [NQ-1:0]    ist
);
    localparam int N_LO   = NQ / 2;
    localparam int A_ERR  = N_LO / 8;
    localparam int A_SRC  = A_ERR + N_LO / 16 + 2 * ((NQ - N_LO) / 32);
    localparam int A_EN   = A_SRC + N_LO / 8;
    localparam logic [NQ*4-1:0] BIT0_MASK = {NQ{4'b0001}};

    logic err_wr;
    logic src_rd;
    assign err_wr = reg_we && int'(reg_addr) >= A_ERR && int'(reg_addr) < A_ERR + N_LO / 16;
    assign src_rd = int'(reg_addr) >= A_SRC && int'(reg_addr) < A_EN;

    // R1: no queue is both empty and full
    a_r1_empty_full_excl: assert property (@(posedge clk) disable iff (rst)
        ((flags_flat & (flags_flat >> 3) & BIT0_MASK) == '0));

    // R3: full always implies nearly full
    a_r3_full_implies_nfull: assert property (@(posedge clk) disable iff (rst)
        (((flags_flat >> 3) & ~(flags_flat >> 2) & BIT0_MASK) == '0));

    // R5: error bits never drop without a write to their word
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        !err_wr |=> ((err_flat & $past(err_flat)) == $past(err_flat)));

    // R6: top bit of every source field reads zero
    a_r6_src_top_zero: assert property (@(posedge clk) disable iff (rst)
        src_rd |-> ((reg_rdata & 32'h8888_8888) == 32'h0));

    // R7: a status bit only sets after its condition was true
    a_r7_set_needs_cond: assert property (@(posedge clk) disable iff (rst)
        ((ist & ~$past(ist) & ~$past(irq_cond)) == '0));
endmodule

bind qstat_irq_gen qsig_chk #(.NQ(NQ), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .flags_flat (flags_flat),
    .err_flat   (err_flat),
    .irq_cond   (irq_cond),
    .ist        (ist_q)
);

// File: tb/qstat_irq_gen_bench.sv
`timescale 1ns/1ps
module qstat_irq_gen_bench;
    localparam int NQ = 64;
    localparam int LW = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NQ*LW-1:0] fill_lvl;
    logic [NQ*3-1:0]  ne_wm;
    logic [NQ*3-1:0]  nf_wm;
    logic [31:0]      ovf_evt = '0;
    logic [31:0]      unf_evt = '0;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NQ-1:0]    irq_out;

    int fill_i [NQ];
    int nwm_i  [NQ];
    int fwm_i  [NQ];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        bit          is_irq;
        logic [63:0] exp;
        logic [63:0] mask;
        string       tag;
    } sb_item_t;
    sb_item_t sb [$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            fill_lvl[i*LW +: LW] = LW'(fill_i[i]);
            ne_wm[i*3 +: 3]      = 3'(nwm_i[i]);
            nf_wm[i*3 +: 3]      = 3'(fwm_i[i]);
        end
    end

    qstat_irq_gen u_qstat_irq_gen (
        .clk (clk), .rst (rst), .fill_lvl (fill_lvl), .ne_wm (ne_wm), .nf_wm (nf_wm),
        .ovf_evt (ovf_evt), .unf_evt (unf_evt), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_out (irq_out)
    );

    // ---------------- reference model ----------------
    function automatic int thr(int c);
        return (c == 0) ? 0 : (1 << (c - 1));
    endfunction

    function automatic logic [3:0] mflags(int q);
        logic e, ne, nf, f;
        e  = (fill_i[q] == 0);
        ne = (fill_i[q] <= thr(nwm_i[q]));
        nf = ((64 - fill_i[q]) <= thr(fwm_i[q]));
        f  = (fill_i[q] == 64);
        return {f, nf, ne, e};
    endfunction

    function automatic logic [31:0] m_stat(int w);
        logic [31:0] r;
        for (int k = 0; k < 8; k++) r[k*4 +: 4] = mflags(w*8 + k);
        return r;
    endfunction

    function automatic logic [31:0] m_up(int bitpos);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[k] = mflags(32 + k)[bitpos];
        return r;
    endfunction

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [63:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? irq_out : {32'b0, reg_rdata};
            n_chk++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic chk_reg(int a, logic [31:0] exp, logic [31:0] mask, string tag);
        sb_item_t it;
        @(posedge clk); #1;
        reg_addr = 4'(a);
        it.is_irq = 0; it.exp = {32'b0, exp}; it.mask = {32'b0, mask}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_irq(logic [63:0] exp, logic [63:0] mask, string tag);
        sb_item_t it;
        @(posedge clk); #1;
        it.is_irq = 1; it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk_status_words(string tag);
        for (int w = 0; w < 4; w++) chk_reg(w, m_stat(w), '1, tag);
        chk_reg(6, m_up(1), '1, {tag, " R4 upper nearly empty"});
        chk_reg(7, m_up(3), '1, {tag, " R4 upper full"});
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int tf [8];
        int ff [8];
        for (int i = 0; i < NQ; i++) begin fill_i[i] = 0; nwm_i[i] = 0; fwm_i[i] = 0; end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state of every word
        chk_status_words("R10 reset R1");
        for (int a = 4; a < 6; a++)   chk_reg(a, 32'h0, '1, "R10 reset errors");
        for (int a = 8; a < 16; a++)  chk_reg(a, 32'h0, '1, "R10 reset config R7");
        chk_irq('0, '1, "R10 reset irq");

        // R1 R2 R3 R4: several fill and watermark patterns, with boundary queues
        for (int pat = 0; pat < 3; pat++) begin
            tick();
            for (int i = 0; i < NQ; i++) begin
                fill_i[i] = (i*7 + pat*13) % 65;
                nwm_i[i]  = (i + pat) % 8;
                fwm_i[i]  = (i*3 + pat*5) % 8;
            end
            fill_i[0]  = 64;
            fill_i[1]  = thr(nwm_i[1]);
            fill_i[2]  = 64 - thr(fwm_i[2]);
            fill_i[3]  = thr(nwm_i[3]) + 1;
            fill_i[33] = thr(nwm_i[33]);
            fill_i[34] = 64;
            chk_status_words("R1 R2 R3 pattern");
        end

        // R10: read-only words ignore writes
        foreach (tf[k]) tf[k] = 0;
        wr(0, '1); wr(1, '1); wr(2, '1); wr(3, '1); wr(6, '0); wr(7, '1);
        chk_status_words("R10 ro write");

        // R5: sticky error bits
        tick(); ovf_evt[5] = 1'b1; unf_evt[20] = 1'b1;
        tick(); ovf_evt = '0; unf_evt = '0;
        chk_reg(4, 32'h0000_0800, '1, "R5 overflow q5");
        chk_reg(5, 32'h0000_0100, '1, "R5 underflow q20");
        repeat (3) tick();
        chk_reg(4, 32'h0000_0800, '1, "R5 overflow holds");
        wr(4, 32'h0000_0800);
        chk_reg(4, 32'h0, '1, "R5 overflow cleared");
        wr(5, 32'h0000_0100);
        chk_reg(5, 32'h0, '1, "R5 underflow cleared");
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h0000_0100; unf_evt[20] = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; unf_evt = '0;
        chk_reg(5, 32'h0000_0100, '1, "R5 set wins over clear");

        // R6 R7 R8: sources, latching and gating
        tick();
        for (int i = 0; i < NQ; i++) begin fill_i[i] = 10; nwm_i[i] = 0; fwm_i[i] = 0; end
        repeat (2) tick();
        wr(14, '1); wr(15, '1);
        chk_reg(14, 32'h0, '1, "R7 status cleared");
        wr(8, 32'h000C_B000);
        chk_reg(8, 32'h0004_3000, '1, "R6 source readback top bit zero");
        wr(12, 32'h0000_0018);
        chk_reg(12, 32'h0000_0018, '1, "R8 enable readback");
        chk_reg(14, 32'h0000_0010, 32'h18, "R6 R7 not-empty source latches");
        chk_irq(64'h10, 64'h18, "R8 irq q4 only");
        tick(); fill_i[3] = 64;
        chk_reg(14, 32'h0000_0018, 32'h18, "R7 full source latches");
        chk_irq(64'h18, 64'h18, "R8 irq q3 q4");
        wr(14, 32'h0000_0010);
        chk_reg(14, 32'h0000_0008, 32'h18, "R7 no relatch while steady");
        wr(12, 32'h0000_0010);
        chk_irq(64'h0, 64'h18, "R8 gated by enable");
        chk_reg(14, 32'h0000_0008, 32'h18, "R8 status kept when disabled");

        // R6 R7: all eight codes on queue 0 (thresholds 4 and 4)
        tf = '{0, 3, 62, 64, 10, 10, 10, 10};
        ff = '{10, 10, 10, 10, 0, 3, 62, 64};
        tick(); nwm_i[0] = 3; fwm_i[0] = 3;
        for (int c = 0; c < 8; c++) begin
            tick(); fill_i[0] = ff[c];
            wr(8, 32'(c));
            wr(14, 32'h1);
            chk_reg(14, 32'h0, 32'h1, "R6 R7 condition false");
            tick(); fill_i[0] = tf[c];
            chk_reg(14, 32'h1, 32'h1, "R6 R7 condition rises");
        end

        // R9: upper queues use nearly empty regardless of other flags
        tick(); fill_i[41] = 64;
        chk_reg(15, 32'h0, 32'h200, "R9 full does not latch upper");
        tick(); nwm_i[40] = 5;
        chk_reg(15, 32'h0000_0100, 32'h100, "R9 nearly empty latches upper");
        wr(13, 32'h0000_0100);
        chk_irq(64'h1 << 40, 64'h3 << 40, "R9 R8 upper irq");

        repeat (3) tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule